// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interrupt delivery request into a series of per-processor inject strobes. A request carries an 8-bit destination, a bit that selects physical or logical addressing, a 3-bit delivery mode, a vector and a trigger-mode bit. The resolver compares the destination against a table of per-processor inputs: a present flag, a physical ID and a logical ID for each of up to 16 processors. From that comparison it forms a target set.

In fixed mode the vector goes to every processor in the target set, one strobe per cycle, from the lowest index upwards. In lowest-priority mode exactly one target gets the vector. That target is chosen by a rotating round-robin pointer, not by comparing processor priorities. Any other delivery mode delivers nothing and raises a one-cycle flag.

The request side uses a valid/ready handshake. Ready is high only while the resolver is idle, so a new request is taken only after the last strobe of the previous one has gone out.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical mode (`req_logical`=0) with destination 0xFF, every processor whose `cpu_present` bit is set is a target.
- R2: In physical mode with any destination other than 0xFF, the only target is the lowest-index present processor whose physical ID equals the destination. If no present processor matches, there is no target.
- R3: In logical mode (`req_logical`=1) with destination 0x00, there is no target.
- R4: In logical mode with a non-zero destination, the targets are all present processors whose 8-bit logical ID ANDed with the destination is non-zero.
- R5: When the target set is empty, no strobe is issued and `req_ready` is high again in the cycle after acceptance.
- R6: Delivery mode 0 (fixed) issues one strobe per cycle to each target, in ascending index order. Every strobe carries the request's vector and trigger bit.
- R7: Delivery mode 1 (lowest-priority) issues exactly one strobe. It goes to the first target at or above the round-robin pointer, wrapping past the top index to index 0. The pointer then moves to the chosen index plus one, modulo the processor count. The pointer is 0 after reset and stays unchanged when the target set is empty.
- R8: Delivery modes 2 to 7 issue no strobe. `unsupported` is high for exactly the one cycle after acceptance.
- R9: `req_ready` is high only when idle. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. The first strobe appears in the cycle after acceptance, `req_ready` stays low while strobes are issued, and it returns high in the cycle after the last strobe. At most one strobe bit is high in any cycle.
- R10: After reset, `req_ready` is high, `inj_strobe` is zero and `unsupported` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Resolver idle and able to accept a request |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical addressing |
| req_dmode | input | 3 | Delivery mode: 0 fixed, 1 lowest-priority, others unsupported |
| req_vector | input | 8 | Interrupt vector |
| req_trig | input | 1 | Trigger mode passed through with each strobe |
| cpu_present | input | 16 | One present flag per processor |
| cpu_phys_id | input | 128 | Physical ID of processor i in bits [8i+7:8i] |
| cpu_log_id | input | 128 | Logical ID of processor i in bits [8i+7:8i] |
| inj_strobe | output | 16 | One-hot inject strobe, one bit per processor |
| inj_vector | output | 8 | Vector that goes with the strobe |
| inj_trig | output | 1 | Trigger mode that goes with the strobe |
| unsupported | output | 1 | One-cycle pulse marking a rejected delivery mode |

## Verification
A corrupted pending-target register shows up on the first strobe cycle after acceptance: a strobe goes to a processor that is not a target, or strobes arrive out of ascending order. A stale pending bit shows up as `req_ready` staying low one cycle too long. A wrong round-robin pointer stays hidden through fixed-mode traffic. It becomes visible only on the next lowest-priority request, as a strobe on the wrong processor. For that reason the bench issues several lowest-priority requests in a row, one of which wraps the pointer. The scoreboard compares every strobe cycle by cycle, so a fault is reported in the cycle it first reaches the ports.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
    localparam int DMODE_W = 3;
    localparam logic [DMODE_W-1:0] DM_FIXED  = 3'd0;
    localparam logic [DMODE_W-1:0] DM_LOWEST = 3'd1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } rsv_state_e;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] first_o
);
    // isolate the lowest set bit
    assign first_o = vec_i & (~vec_i + W'(1));
endmodule

// File: rtl/irq_dest_mask.sv
module irq_dest_mask #(
    parameter int NUM_CPU = 16,
    parameter int ID_W    = 8
) (
    input  logic [ID_W-1:0]         dest_i,
    input  logic                    logical_i,
    input  logic [NUM_CPU-1:0]      present_i,
    input  logic [NUM_CPU*ID_W-1:0] phys_id_i,
    input  logic [NUM_CPU*ID_W-1:0] log_id_i,
    output logic [NUM_CPU-1:0]      mask_o
);
    localparam logic [ID_W-1:0] BCAST = '1;

    logic [NUM_CPU-1:0] phys_hit;
    logic [NUM_CPU-1:0] log_hit;
    logic [NUM_CPU-1:0] phys_first;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        assign phys_hit[g] = present_i[g] && (phys_id_i[g*ID_W +: ID_W] == dest_i);
        assign log_hit[g]  = present_i[g] && ((log_id_i[g*ID_W +: ID_W] & dest_i) != '0);
    end

    irq_first_set #(.W(NUM_CPU)) u_phys_first (
        .vec_i  (phys_hit),
        .first_o(phys_first)
    );

    always_comb begin
        if (logical_i) begin
            mask_o = (dest_i == '0) ? '0 : log_hit;
        end else if (dest_i == BCAST) begin
            mask_o = present_i;
        end else begin
            mask_o = phys_first;
        end
    end

    always_comb begin
        if (!logical_i && dest_i != BCAST) begin
            a_r2_single_phys: assert ($onehot0(mask_o));
        end
        a_r4_only_present: assert ((mask_o & ~present_i) == '0);
    end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NUM_CPU = 16,
    parameter int PTR_W   = 4
) (
    input  logic [NUM_CPU-1:0] mask_i,
    input  logic [PTR_W-1:0]   ptr_i,
    output logic [NUM_CPU-1:0] onehot_o,
    output logic [PTR_W-1:0]   idx_o,
    output logic               found_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // scan downward in offset so the nearest candidate wins
        for (int off = NUM_CPU - 1; off >= 0; off--) begin
            int c;
            c = int'(ptr_i) + off;
            if (c >= NUM_CPU) c = c - NUM_CPU;
            if (mask_i[c]) begin
                found_o = 1'b1;
                idx_o   = PTR_W'(c);
            end
        end
        onehot_o = found_o ? (NUM_CPU'(1) << idx_o) : '0;
    end

    always_comb begin
        if (found_o) begin
            a_r7_pick_in_mask: assert ((onehot_o & ~mask_i) == '0);
        end
    end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int ID_W    = 8,
    parameter int VEC_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ID_W-1:0]         req_dest,
    input  logic                    req_logical,
    input  logic [DMODE_W-1:0]      req_dmode,
    input  logic [VEC_W-1:0]        req_vector,
    input  logic                    req_trig,
    input  logic [NUM_CPU-1:0]      cpu_present,
    input  logic [NUM_CPU*ID_W-1:0] cpu_phys_id,
    input  logic [NUM_CPU*ID_W-1:0] cpu_log_id,
    output logic [NUM_CPU-1:0]      inj_strobe,
    output logic [VEC_W-1:0]        inj_vector,
    output logic                    inj_trig,
    output logic                    unsupported
);
    localparam int PTR_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_CPU - 1);

    typedef struct packed {
        rsv_state_e         st;
        logic [NUM_CPU-1:0] pend;
        logic [PTR_W-1:0]   ptr;
        logic [VEC_W-1:0]   vec;
        logic               trig;
        logic               unsup;
    } ctx_t;

    ctx_t s_d, s_q;

    logic [NUM_CPU-1:0] tgt_mask;
    logic [NUM_CPU-1:0] rr_onehot;
    logic [PTR_W-1:0]   rr_idx;
    logic               rr_found;
    logic [NUM_CPU-1:0] pend_first;
    logic [NUM_CPU-1:0] pend_rest;
    logic               accept;

    irq_dest_mask #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_mask (
        .dest_i   (req_dest),
        .logical_i(req_logical),
        .present_i(cpu_present),
        .phys_id_i(cpu_phys_id),
        .log_id_i (cpu_log_id),
        .mask_o   (tgt_mask)
    );

    irq_rr_pick #(.NUM_CPU(NUM_CPU), .PTR_W(PTR_W)) u_rr (
        .mask_i  (tgt_mask),
        .ptr_i   (s_q.ptr),
        .onehot_o(rr_onehot),
        .idx_o   (rr_idx),
        .found_o (rr_found)
    );

    irq_first_set #(.W(NUM_CPU)) u_pend_first (
        .vec_i  (s_q.pend),
        .first_o(pend_first)
    );

    assign pend_rest = s_q.pend & ~pend_first;
    assign accept    = req_valid && (s_q.st == ST_IDLE);

    always_comb begin
        s_d       = s_q;
        s_d.unsup = 1'b0;
        if (accept) begin
            s_d.vec  = req_vector;
            s_d.trig = req_trig;
            if (req_dmode == DM_FIXED) begin
                s_d.pend = tgt_mask;
                s_d.st   = (tgt_mask != '0) ? ST_SEND : ST_IDLE;
            end else if (req_dmode == DM_LOWEST) begin
                s_d.pend = rr_onehot;
                if (rr_found) begin
                    s_d.st  = ST_SEND;
                    s_d.ptr = (rr_idx == PTR_LAST) ? '0 : rr_idx + PTR_W'(1);
                end
            end else begin
                s_d.pend  = '0;
                s_d.unsup = 1'b1;
            end
        end else if (s_q.st == ST_SEND) begin
            s_d.pend = pend_rest;
            if (pend_rest == '0) s_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= ctx_t'('0);
        else        s_q <= s_d;
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign inj_strobe  = (s_q.st == ST_SEND) ? pend_first : '0;
    assign inj_vector  = s_q.vec;
    assign inj_trig    = s_q.trig;
    assign unsupported = s_q.unsup;

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_strobe));
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (inj_strobe == '0));
    a_r9_busy_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (inj_strobe != '0));
    a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_dmode > DM_LOWEST) |=> (unsupported && inj_strobe == '0));
    a_r7_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_dmode == DM_LOWEST && tgt_mask != '0)
        |=> (inj_strobe != '0) ##1 req_ready);
    a_r5_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tgt_mask == '0) |=> req_ready);
endmodule

// File: tb/irq_dest_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_dest_resolver_tb_top;
    localparam int N = 16;

    typedef struct {
        int          idx;
        logic [7:0]  vec;
        logic        trig;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [7:0]    req_dest = '0;
    logic          req_logical = 1'b0;
    logic [2:0]    req_dmode = '0;
    logic [7:0]    req_vector = '0;
    logic          req_trig = 1'b0;
    logic [N-1:0]  pres = '0;
    logic [7:0]    pid [N];
    logic [7:0]    lid [N];
    logic [N*8-1:0] phys_bus;
    logic [N*8-1:0] log_bus;
    logic [N-1:0]  inj_strobe;
    logic [7:0]    inj_vector;
    logic          inj_trig;
    logic          unsupported;

    int    n_chk = 0;
    int    n_bad = 0;
    int    rr_ptr = 0;
    item_t q[$];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            phys_bus[i*8 +: 8] = pid[i];
            log_bus[i*8 +: 8]  = lid[i];
        end
    end

    irq_dest_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_logical(req_logical), .req_dmode(req_dmode),
        .req_vector(req_vector), .req_trig(req_trig), .cpu_present(pres),
        .cpu_phys_id(phys_bus), .cpu_log_id(log_bus), .inj_strobe(inj_strobe),
        .inj_vector(inj_vector), .inj_trig(inj_trig), .unsupported(unsupported)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] model_mask(input logic [7:0] d, input logic lg);
        logic [N-1:0] m = '0;
        if (lg) begin
            if (d != 8'h00)
                for (int i = 0; i < N; i++) if (pres[i] && (lid[i] & d) != 0) m[i] = 1'b1;
        end else if (d == 8'hFF) begin
            m = pres;
        end else begin
            for (int i = N - 1; i >= 0; i--)
                if (pres[i] && pid[i] == d) m = N'(1) << i;
        end
        return m;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && inj_strobe != '0) begin
            if (q.size() == 0) begin
                check(1'b0, "R9", "unexpected strobe", longint'(inj_strobe), 0);
            end else begin
                item_t it;
                it = q.pop_front();
                check(inj_strobe == (N'(1) << it.idx), it.tag, "strobe",
                      longint'(inj_strobe), longint'(N'(1) << it.idx));
                check(inj_vector == it.vec && inj_trig == it.trig, it.tag, "vector/trig",
                      longint'({inj_trig, inj_vector}), longint'({it.trig, it.vec}));
            end
        end
    end

    task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] m,
                        input logic [7:0] v, input logic t, input string tag);
        logic [N-1:0] mk;
        int cnt = 0;
        mk = model_mask(d, lg);
        if (m == 3'd0) begin
            for (int i = 0; i < N; i++)
                if (mk[i]) begin q.push_back('{i, v, t, tag}); cnt++; end
        end else if (m == 3'd1 && mk != '0) begin
            int pick = -1;
            for (int off = N - 1; off >= 0; off--)
                if (mk[(rr_ptr + off) % N]) pick = (rr_ptr + off) % N;
            q.push_back('{pick, v, t, tag});
            rr_ptr = (pick + 1) % N;
            cnt = 1;
        end
        @(negedge clk);
        check(req_ready == 1'b1, tag, "ready before request", longint'(req_ready), 1);
        req_valid = 1'b1; req_dest = d; req_logical = lg; req_dmode = m;
        req_vector = v; req_trig = t;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == (cnt == 0), "R9", "ready after accept", longint'(req_ready),
              longint'(cnt == 0));
        check(unsupported == (m > 3'd1), "R8", "unsupported flag", longint'(unsupported),
              longint'(m > 3'd1));
        repeat (cnt) @(negedge clk);
        check(req_ready == 1'b1, tag, "ready after last strobe", longint'(req_ready), 1);
        check(q.size() == 0, tag, "strobes outstanding", longint'(q.size()), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            pid[i] = 8'h40 + 8'(i);
            lid[i] = 8'(1 << (i % 8));
        end
        pid[2] = 8'h20; pid[5] = 8'h20; pid[9] = 8'h20;
        pres = 16'hDF7B;   // processors 2, 7 and 13 absent
        repeat (3) @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10", "ready in reset", longint'(req_ready), 1);
        check(inj_strobe == '0, "R10", "strobe in reset", longint'(inj_strobe), 0);
        check(unsupported == 1'b0, "R10", "flag in reset", longint'(unsupported), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 + R6: broadcast, fixed, ascending order
        send(8'hFF, 1'b0, 3'd0, 8'h31, 1'b0, "R1");
        // R2: first present match is processor 5 (2 is absent)
        send(8'h20, 1'b0, 3'd0, 8'h32, 1'b1, "R2");
        send(8'h4B, 1'b0, 3'd0, 8'h33, 1'b0, "R2");
        // R5: no physical match
        send(8'h77, 1'b0, 3'd0, 8'h34, 1'b0, "R5");
        // R3: logical zero
        send(8'h00, 1'b1, 3'd0, 8'h35, 1'b0, "R3");
        send(8'h00, 1'b1, 3'd1, 8'h36, 1'b0, "R3");
        // R4 + R6: logical set 0x05 and 0x90
        send(8'h05, 1'b1, 3'd0, 8'h37, 1'b1, "R4");
        send(8'h90, 1'b1, 3'd0, 8'h38, 1'b0, "R6");
        // R7: round-robin rotation with wrap
        send(8'h05, 1'b1, 3'd1, 8'h41, 1'b1, "R7");
        send(8'h05, 1'b1, 3'd1, 8'h42, 1'b0, "R7");
        send(8'h05, 1'b1, 3'd1, 8'h43, 1'b1, "R7");
        send(8'h05, 1'b1, 3'd1, 8'h44, 1'b0, "R7");
        send(8'hFF, 1'b0, 3'd1, 8'h45, 1'b0, "R7");
        // R8: rejected modes
        send(8'hFF, 1'b0, 3'd2, 8'h51, 1'b0, "R8");
        send(8'h05, 1'b1, 3'd7, 8'h52, 1'b1, "R8");
        // R7 again after rejected modes: pointer untouched
        send(8'hFF, 1'b0, 3'd1, 8'h53, 1'b1, "R7");
        // R1 with a changed present set
        pres = 16'h8001;
        send(8'hFF, 1'b0, 3'd0, 8'h61, 1'b1, "R1");
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule